// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host reach a small bank of 8-bit codec configuration registers through only two 32-bit memory-mapped words. The command word holds a 7-bit internal address, an 8-bit write value and a write-request flag. The data word returns the byte held at the current internal address, together with the live state of the codec interrupt line.

Internal writes are posted. A command with the request flag set loads the address and value into the bridge. The bit then stays high, as a busy indication, for a fixed number of cycles. When it drops, the target register holds the new value. Reads work in two steps. The host first sets the address field, which can be done without a write request. The addressed byte then passes through a fixed-depth read pipeline and appears in the data word a set number of cycles later.

The bridge holds the register file itself. This covers the reset defaults, a read-only status location, two unimplemented holes and the unused space above the last register.

Top module: `cb_bridge`

## Requirements
- R1: The command word is at byte offset 0x00 and the data word at 0x04. A host read of any other offset returns zero. Bits 31:17 of the command word and bits 31:9 of the data word always read zero. Read data appears on `host_rdata` one clock after the read strobe.
- R2: The command-word fields are: bit 16 is the write request / busy flag, bits 14:8 are the internal address, and bits 7:0 are the write value. Reading the command word returns the address and value last accepted. Every field reads zero after reset.
- R3: A command write with bit 16 set is accepted only when the bridge is idle. After acceptance, bit 16 reads 1 for exactly `WR_LAT` consecutive read cycles (4 by default) and then reads 0. By that point the register has been updated.
- R4: A command-word write that arrives while bit 16 is set is ignored entirely. The address, the value and the target register all stay unchanged.
- R5: A command write with bit 16 clear updates the address and value fields only. No register is written and the busy flag stays 0.
- R6: Bits 7:0 of the data word give the register at the current address, valid from `RD_LAT` cycles (6 by default) after the address or the register changes. Bit 8 gives `codec_irq` as sampled on the read.
- R7: After reset, these registers hold the listed values: 0x01 and 0x02 hold 0xC3, 0x03 holds 0x90, 0x04 holds 0x98, 0x07 holds 0xB1, 0x12 through 0x15 hold 0x06, and 0x1F holds 0x34. Every other implemented writable register holds 0x00.
- R8: Address 0x00 reads the `codec_status` input, and writes to it are discarded.
- R9: Addresses 0x05 and 0x1C, and every address from 0x24 upward, read as zero and ignore writes.
- R10: Every other address in 0x01 through 0x23 reads back the last value committed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_offset | input | 4 | Byte offset of the word accessed |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| codec_irq | input | 1 | Codec interrupt line, reflected in data word bit 8 |
| codec_status | input | 8 | Live codec status byte shown at address 0x00 |

## Verification
The bench builds the bridge with its default parameters: 36 registers, a write latency of 4 and a read latency of 6. With these values, back-to-back command-word reads cover every busy cycle of a write. The test checks that the flag is high for exactly four samples and drops on the fifth. A second command sent during that window shows the drop rule at work. Sweeping the address across the whole map reaches every reset default, the status location, both holes and the out-of-range space.

// File: rtl/cb_pkg.sv
package cb_pkg;

  localparam int unsigned CB_ADDR_W  = 7;
  localparam int unsigned CB_DATA_W  = 8;
  localparam int unsigned CB_OFF_W   = 4;
  localparam int unsigned CB_N_REGS  = 36;
  localparam int unsigned CB_HOLE_A  = 5;
  localparam int unsigned CB_HOLE_B  = 28;

  // Host word layout
  localparam logic [CB_OFF_W-1:0] CB_OFF_CMD = 4'h0;
  localparam logic [CB_OFF_W-1:0] CB_OFF_DAT = 4'h4;
  localparam int unsigned CB_REQ_BIT   = 16;
  localparam int unsigned CB_ADDR_LSB  = 8;
  localparam int unsigned CB_IRQ_BIT   = 8;

  typedef enum logic [1:0] {
    CB_KIND_STATUS,
    CB_KIND_HOLE,
    CB_KIND_RW
  } cb_kind_e;

  function automatic cb_kind_e cb_kind(input int unsigned idx);
    if (idx == 0)
      return CB_KIND_STATUS;
    else if (idx == CB_HOLE_A || idx == CB_HOLE_B || idx >= CB_N_REGS)
      return CB_KIND_HOLE;
    else
      return CB_KIND_RW;
  endfunction

  function automatic logic [CB_DATA_W-1:0] cb_reset_value(input int unsigned idx);
    logic [CB_DATA_W-1:0] v;
    case (idx)
      1, 2:            v = 8'hC3;
      3:               v = 8'h90;
      4:               v = 8'h98;
      7:               v = 8'hB1;
      18, 19, 20, 21:  v = 8'h06;
      31:              v = 8'h34;
      default:         v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cb_wr_engine.sv
module cb_wr_engine #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_data,
  output logic              commit
);
  localparam int unsigned CNT_W = (WR_LAT < 2) ? 1 : $clog2(WR_LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_LAT - 1);

  logic [CNT_W-1:0] cnt;

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur_addr <= '0;
      cur_data <= '0;
    end else if (cmd_valid && !busy) begin
      cur_addr <= cmd_addr;
      cur_data <= cmd_data;
      if (cmd_req) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cb_regfile.sv
module cb_regfile
  import cb_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_REGS = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned FLAT_W = N_REGS * DATA_W;

  logic [FLAT_W-1:0] flat;

  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
    if (cb_kind(gi) == CB_KIND_STATUS) begin : g_status
      assign flat[gi*DATA_W +: DATA_W] = status_in;
    end else if (cb_kind(gi) == CB_KIND_HOLE) begin : g_hole
      assign flat[gi*DATA_W +: DATA_W] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= cb_reset_value(gi);
        else if (wr_en && (wr_addr == ADDR_W'(gi)))
          q <= wr_data;
      end
      assign flat[gi*DATA_W +: DATA_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < N_REGS)
      rd_data = flat[int'(rd_addr)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cb_rd_pipe.sv
module cb_rd_pipe #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stg [DEPTH];

  for (genvar gs = 0; gs < DEPTH; gs++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)       stg[gs] <= '0;
      else if (gs == 0) stg[gs] <= din;
      else              stg[gs] <= stg[(gs == 0) ? 0 : gs-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/cb_bridge.sv
module cb_bridge
  import cb_pkg::*;
#(
  parameter int unsigned N_REGS = CB_N_REGS,
  parameter int unsigned WR_LAT = 4,
  parameter int unsigned RD_LAT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_en,
  input  logic                 host_we,
  input  logic [CB_OFF_W-1:0]  host_offset,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  input  logic                 codec_irq,
  input  logic [CB_DATA_W-1:0] codec_status
);
  localparam int unsigned AW = CB_ADDR_W;
  localparam int unsigned DW = CB_DATA_W;

  logic          cmd_valid;
  logic          wr_busy;
  logic          wr_commit;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  logic [DW-1:0] rf_rd_data;
  logic [DW-1:0] rd_byte;

  assign cmd_valid = host_en && host_we && (host_offset == CB_OFF_CMD);

  cb_wr_engine #(.ADDR_W(AW), .DATA_W(DW), .WR_LAT(WR_LAT)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_req  (host_wdata[CB_REQ_BIT]),
    .cmd_addr (host_wdata[CB_ADDR_LSB +: AW]),
    .cmd_data (host_wdata[DW-1:0]),
    .busy     (wr_busy),
    .cur_addr (cur_addr),
    .cur_data (cur_data),
    .commit   (wr_commit)
  );

  cb_regfile #(.ADDR_W(AW), .DATA_W(DW), .N_REGS(N_REGS)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_commit),
    .wr_addr  (cur_addr),
    .wr_data  (cur_data),
    .status_in(codec_status),
    .rd_addr  (cur_addr),
    .rd_data  (rf_rd_data)
  );

  cb_rd_pipe #(.DATA_W(DW), .DEPTH(RD_LAT)) u_rp (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rf_rd_data),
    .dout (rd_byte)
  );

  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (host_offset == CB_OFF_CMD) begin
      rd_word[CB_REQ_BIT]            = wr_busy;
      rd_word[CB_ADDR_LSB +: AW]     = cur_addr;
      rd_word[DW-1:0]                = cur_data;
    end else if (host_offset == CB_OFF_DAT) begin
      rd_word[CB_IRQ_BIT]            = codec_irq;
      rd_word[DW-1:0]                = rd_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   host_rdata <= '0;
    else if (host_en && !host_we) host_rdata <= rd_word;
  end
endmodule

// File: rtl/cb_bridge_chk.sv
module cb_bridge_chk
  import cb_pkg::*;
#(
  parameter int unsigned N_REGS = CB_N_REGS,
  parameter int unsigned WR_LAT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 commit,
  input logic [CB_ADDR_W-1:0] cur_addr,
  input logic [CB_DATA_W-1:0] rf_rd,
  input logic [CB_DATA_W-1:0] codec_status,
  input logic [31:0]          host_rdata
);
  logic [7:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_run <= '0;
    else                 busy_run <= busy_run + 1'b1;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy_run == 8'(WR_LAT - 1))); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 8'(WR_LAT))); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr)); // R4
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_addr == 7'(CB_HOLE_A) || cur_addr == 7'(CB_HOLE_B) || int'(cur_addr) >= N_REGS)
      |-> (rf_rd == '0)); // R9
  AST_STATUS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_addr == '0) |-> (rf_rd == codec_status)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[31:17] == '0); // R1
endmodule

bind cb_bridge cb_bridge_chk #(.N_REGS(N_REGS), .WR_LAT(WR_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (wr_busy),
  .commit      (wr_commit),
  .cur_addr    (cur_addr),
  .rf_rd       (rf_rd_data),
  .codec_status(codec_status),
  .host_rdata  (host_rdata)
);

// File: tb/cb_bridge_test.sv
module cb_bridge_test;
  localparam int WR_LAT = 4;
  localparam int RD_LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_offset = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        codec_irq = 1'b0;
  logic [7:0]  codec_status = 8'h5A;

  always #2.5 clk = ~clk;

  cb_bridge #(.N_REGS(36), .WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_offset(host_offset), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .codec_irq(codec_irq), .codec_status(codec_status)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_flag;

  // Monitor: a read strobe sampled at a rising edge has its result compared at the next falling edge
  always @(posedge clk) rd_flag <= rst_n && host_en && !host_we;

  always @(negedge clk) begin
    if (rd_flag === 1'b1 && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (host_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", t, host_rdata, e);
      end
    end
  end

  function automatic logic [7:0] model_reg(input int a, input logic [7:0] st);
    case (a)
      0:              return st;
      1, 2:           return 8'hC3;
      3:              return 8'h90;
      4:              return 8'h98;
      7:              return 8'hB1;
      18, 19, 20, 21: return 8'h06;
      31:             return 8'h34;
      default:        return 8'h00;
    endcase
  endfunction

  task automatic host_write(input logic [3:0] off, input logic [31:0] d);
    host_en = 1'b1; host_we = 1'b1; host_offset = off; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] off, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    host_en = 1'b1; host_we = 1'b0; host_offset = off;
    @(negedge clk);
    host_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd_word(input logic req, input logic [6:0] a, input logic [7:0] d);
    return {15'b0, req, 1'b0, a, d};
  endfunction

  function automatic logic [31:0] dat_word(input logic irq, input logic [7:0] b);
    return {23'b0, irq, b};
  endfunction

  task automatic set_addr(input logic [6:0] a);
    host_write(4'h0, cmd_word(1'b0, a, 8'h00));
    idle(RD_LAT + 2);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
    host_write(4'h0, cmd_word(1'b1, a, d));
    idle(WR_LAT + RD_LAT + 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state of the command word; R1: unmapped offset reads zero
    host_read(4'h0, 32'h0, "R2 reset command word");
    host_read(4'h8, 32'h0, "R1 unmapped offset");
    idle(RD_LAT + 2);
    // R8/R6: address 0 shows the status input
    host_read(4'h4, dat_word(1'b0, 8'h5A), "R8 status at address 0");

    // R7: sweep the whole map for reset defaults (holes included, R9)
    for (int a = 0; a < 40; a++) begin
      set_addr(7'(a));
      host_read(4'h4, dat_word(1'b0, model_reg(a, 8'h5A)), $sformatf("R7 default at %02h", a));
    end

    // R3: busy for exactly WR_LAT reads, then clear; R10 value committed
    host_write(4'h0, cmd_word(1'b1, 7'h07, 8'h3C));
    for (int k = 0; k < WR_LAT; k++)
      host_read(4'h0, cmd_word(1'b1, 7'h07, 8'h3C), "R3 busy high");
    host_read(4'h0, cmd_word(1'b0, 7'h07, 8'h3C), "R3 busy cleared");
    idle(RD_LAT + 2);
    host_read(4'h4, dat_word(1'b0, 8'h3C), "R10 readback at 07");

    // R4: a second command during busy is dropped
    host_write(4'h0, cmd_word(1'b1, 7'h08, 8'h11));
    host_write(4'h0, cmd_word(1'b1, 7'h09, 8'h22));
    idle(WR_LAT + 2);
    host_read(4'h0, cmd_word(1'b0, 7'h08, 8'h11), "R4 command fields kept");
    set_addr(7'h09);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R4 dropped write did not land");
    set_addr(7'h08);
    host_read(4'h4, dat_word(1'b0, 8'h11), "R10 readback at 08");

    // R5: address-only command performs no write
    host_write(4'h0, cmd_word(1'b0, 7'h0A, 8'hFF));
    host_read(4'h0, cmd_word(1'b0, 7'h0A, 8'hFF), "R5 no busy on address-only");
    idle(RD_LAT + 2);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R5 register untouched");

    // R8: writes to status discarded, live input tracked
    write_reg(7'h00, 8'hEE);
    host_read(4'h4, dat_word(1'b0, 8'h5A), "R8 write to status discarded");
    codec_status = 8'hA5;
    idle(RD_LAT + 2);
    host_read(4'h4, dat_word(1'b0, 8'hA5), "R8 status follows input");

    // R9: holes and out-of-range ignore writes
    write_reg(7'h05, 8'hEE);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R9 hole 05");
    write_reg(7'h1C, 8'hEE);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R9 hole 1C");
    write_reg(7'h24, 8'hEE);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R9 address 24");
    write_reg(7'h7F, 8'hEE);
    host_read(4'h4, dat_word(1'b0, 8'h00), "R9 address 7F");

    // R10: last register in range
    write_reg(7'h23, 8'h81);
    host_read(4'h4, dat_word(1'b0, 8'h81), "R10 readback at 23");

    // R6: interrupt bit and data byte together
    codec_irq = 1'b1;
    set_addr(7'h1F);
    host_read(4'h4, dat_word(1'b1, 8'h34), "R6 irq with data");
    codec_irq = 1'b0;
    host_read(4'h4, dat_word(1'b0, 8'h34), "R6 irq released");

    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule